// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides the operating mode of a CAN protocol engine. Software writes two request bits, one for sleep and one for initialization, and the block answers each with an acknowledge once the mode is actually in effect. The handshake is guarded. A pending request cannot be withdrawn before its acknowledge appears. Sleep is entered only when the bus is idle. Initialization takes effect at once, from any mode.

While the block sleeps it can optionally watch the bus. A dominant bit then ends sleep by itself and raises a wake-up flag, which software clears by writing one. After initialization is released, the engine is held off the bus until it has seen a run of eleven consecutive recessive bits. If the node is bus-off, it must see 128 such runs. The block drives a transmit-recessive override, which is active in every mode except running and during a halting CPU wait/stop. It also drives a configuration-write enable for the bit-timing and filter registers.

Top module: `can_mode_ctrl`

## Requirements
- R1: A pending sleep request moves the block from running to sleep only in a clock where `rx_busy` is 0 and `tx_all_empty` is 1. `sleep_ack` goes high one clock after that condition is sampled.
- R2: A software write of 0 to the sleep request is ignored while `sleep_ack` is low. When `sleep_ack` is high the write is accepted, and the block returns to running one clock later.
- R3: A software write of 0 to the initialization request is ignored while `init_ack` is low.
- R4: A software write of 1 to the sleep request is ignored while `wake_flag` is high.
- R5: The wake-up check applies in sleep when a strobed bus bit is dominant (`bit_strobe`=1, `bus_bit`=0). With `wake_en`=1, the block clears the sleep request, sets `wake_flag` and returns to running on that clock. With `wake_en`=0, the bit has no effect.
- R6: Setting the initialization request raises `init_ack` one clock later from any mode (running, sleep or resynchronization), and `sleep_ack` is low while `init_ack` is high.
- R7: `tx_force_rec` is high whenever the initialization request is set, whenever `halt_in_wait` is high, and whenever the block is not running.
- R8: `cfg_wr_en` is high exactly when both the initialization request and `init_ack` are high.
- R9: After initialization is released, the block returns to running on the strobed recessive bit (`bus_bit`=1) that completes a run of 11 consecutive recessive bits when `bus_off`=0. When `bus_off`=1, it returns on the bit that completes the 128th such run.
- R10: A dominant strobed bit during resynchronization restarts the current consecutive-recessive count but keeps the number of completed runs.
- R11: `init_ack` falls one clock after the initialization request is cleared, and `online` stays low until resynchronization completes.
- R12: `wake_flag` is cleared by a pulse on `wake_clr`, and a set in the same clock wins. A synchronous reset (`rst_n`=0) gives running mode with both requests, both acknowledges and `wake_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_wr | input | 1 | Software write strobe for the sleep request |
| sleep_wdata | input | 1 | Value written to the sleep request |
| init_wr | input | 1 | Software write strobe for the initialization request |
| init_wdata | input | 1 | Value written to the initialization request |
| wake_en | input | 1 | Allow bus activity to end sleep |
| wake_clr | input | 1 | Write-one-to-clear pulse for the wake-up flag |
| halt_in_wait | input | 1 | CPU is in a wait/stop mode that halts the controller |
| rx_busy | input | 1 | A frame is being received |
| tx_all_empty | input | 1 | All transmit buffers are empty |
| bus_off | input | 1 | Engine is in bus-off state |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| bit_strobe | input | 1 | One-clock pulse marking a valid `bus_bit` |
| sleep_req | output | 1 | Current sleep request bit |
| sleep_ack | output | 1 | Sleep mode active |
| init_req | output | 1 | Current initialization request bit |
| init_ack | output | 1 | Initialization mode active |
| wake_flag | output | 1 | Wake-up event pending |
| tx_force_rec | output | 1 | Force the transmit line recessive |
| cfg_wr_en | output | 1 | Configuration registers may be written |
| online | output | 1 | Running mode, engine takes part on the bus |

## Verification
The hardest state to reach is the end of a bus-off rejoin. There the block must leave resynchronization on exactly the bit that completes the 128th recessive run, and an earlier dominant bit must not have cost a completed run. The stimulus releases initialization with `bus_off` held high. It breaks the first run with a dominant bit, then streams strobed recessive bits and checks `online` one bit short of the total and again on the final bit. A second hard spot is the unacknowledged window of one clock after an initialization set, in which a clear must be dropped. The bench writes the clear in exactly that clock.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_SLEEP  = 2'd1,
        MODE_INIT   = 2'd2,
        MODE_RESYNC = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  wake_flag;
    } ctl_s;

endpackage

// File: rtl/can_req_guard.sv
module can_req_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    input  logic set_block,
    input  logic ack,
    input  logic hw_clr,
    output logic req
);

    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (wr_en) begin
            if (wr_val && !set_block) begin
                req_d = 1'b1;
            end else if (!wr_val && ack) begin
                req_d = 1'b0;
            end
        end
        if (hw_clr) begin
            req_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req = req_q;

endmodule

// File: rtl/can_resync_count.sv
module can_resync_count #(
    parameter int RUN_BITS = 11,
    parameter int RUNS_BUSOFF = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic strobe,
    input  logic bit_rec,
    input  logic bus_off,
    output logic done
);

    localparam int BW = $clog2(RUN_BITS + 1);
    localparam int SW = $clog2(RUNS_BUSOFF + 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(RUN_BITS - 1);
    localparam logic [SW-1:0] RUN_LAST = SW'(RUNS_BUSOFF - 1);

    typedef struct packed {
        logic [BW-1:0] bits;
        logic [SW-1:0] runs;
    } cnt_s;

    cnt_s cnt_d, cnt_q;
    logic run_end;

    assign run_end = active && strobe && bit_rec && (cnt_q.bits == BIT_LAST);
    assign done    = run_end && (!bus_off || (cnt_q.runs == RUN_LAST));

    always_comb begin
        cnt_d = cnt_q;
        if (!active) begin
            cnt_d = '0;
        end else if (strobe) begin
            if (!bit_rec) begin
                cnt_d.bits = '0;
            end else if (run_end) begin
                cnt_d.bits = '0;
                if (bus_off) begin
                    cnt_d.runs = cnt_q.runs + 1'b1;
                end
            end else begin
                cnt_d.bits = cnt_q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int RUN_BITS = 11,
    parameter int RUNS_BUSOFF = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_wr,
    input  logic sleep_wdata,
    input  logic init_wr,
    input  logic init_wdata,
    input  logic wake_en,
    input  logic wake_clr,
    input  logic halt_in_wait,
    input  logic rx_busy,
    input  logic tx_all_empty,
    input  logic bus_off,
    input  logic bus_bit,
    input  logic bit_strobe,
    output logic sleep_req,
    output logic sleep_ack,
    output logic init_req,
    output logic init_ack,
    output logic wake_flag,
    output logic tx_force_rec,
    output logic cfg_wr_en,
    output logic online
);

    ctl_s ctl_d, ctl_q;
    logic wake_evt;
    logic resync_done;
    logic bus_idle;

    assign sleep_ack = (ctl_q.mode == MODE_SLEEP);
    assign init_ack  = (ctl_q.mode == MODE_INIT);
    assign online    = (ctl_q.mode == MODE_RUN);
    assign wake_flag = ctl_q.wake_flag;
    assign bus_idle  = !rx_busy && tx_all_empty;

    assign wake_evt = sleep_ack && !init_req && wake_en && bit_strobe && !bus_bit;

    can_req_guard u_sleep_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sleep_wr),
        .wr_val    (sleep_wdata),
        .set_block (ctl_q.wake_flag),
        .ack       (sleep_ack),
        .hw_clr    (wake_evt),
        .req       (sleep_req)
    );

    can_req_guard u_init_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (init_wr),
        .wr_val    (init_wdata),
        .set_block (1'b0),
        .ack       (init_ack),
        .hw_clr    (1'b0),
        .req       (init_req)
    );

    can_resync_count #(
        .RUN_BITS    (RUN_BITS),
        .RUNS_BUSOFF (RUNS_BUSOFF)
    ) u_resync (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (ctl_q.mode == MODE_RESYNC),
        .strobe  (bit_strobe),
        .bit_rec (bus_bit),
        .bus_off (bus_off),
        .done    (resync_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wake_evt) begin
            ctl_d.wake_flag = 1'b1;
        end else if (wake_clr) begin
            ctl_d.wake_flag = 1'b0;
        end

        if (init_req) begin
            ctl_d.mode = MODE_INIT;
        end else begin
            unique case (ctl_q.mode)
                MODE_RUN: begin
                    if (sleep_req && bus_idle) begin
                        ctl_d.mode = MODE_SLEEP;
                    end
                end
                MODE_SLEEP: begin
                    if (!sleep_req || wake_evt) begin
                        ctl_d.mode = MODE_RUN;
                    end
                end
                MODE_INIT: begin
                    ctl_d.mode = MODE_RESYNC;
                end
                MODE_RESYNC: begin
                    if (resync_done) begin
                        ctl_d.mode = MODE_RUN;
                    end
                end
                default: ctl_d.mode = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_RUN, wake_flag: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_force_rec = halt_in_wait || init_req || !online;
    assign cfg_wr_en    = init_req && init_ack;

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_busy,
    input logic tx_all_empty,
    input logic bus_bit,
    input logic bit_strobe,
    input logic sleep_req,
    input logic sleep_ack,
    input logic init_req,
    input logic init_ack,
    input logic wake_flag,
    input logic online
);

    a_r1_sleep_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_ack) |-> $past(!rx_busy && tx_all_empty));

    a_r2_sleep_clr_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !sleep_ack) |=> sleep_req);

    a_r3_init_clr_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !init_ack) |=> init_req);

    a_r4_no_set_when_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !sleep_req) |=> !sleep_req);

    a_r6_init_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && !init_ack) |=> init_ack);

    a_r6_acks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sleep_ack, init_ack}));

    a_r11_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_req) |=> !init_ack);

    a_r9_rejoin_on_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(online) && !$past(sleep_ack)) |-> $past(bit_strobe && bus_bit));

endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_busy      (rx_busy),
    .tx_all_empty (tx_all_empty),
    .bus_bit      (bus_bit),
    .bit_strobe   (bit_strobe),
    .sleep_req    (sleep_req),
    .sleep_ack    (sleep_ack),
    .init_req     (init_req),
    .init_ack     (init_ack),
    .wake_flag    (wake_flag),
    .online       (online)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;

    logic clk = 1'b0;
    logic rst_n, sleep_wr, sleep_wdata, init_wr, init_wdata, wake_en, wake_clr;
    logic halt_in_wait, rx_busy, tx_all_empty, bus_off, bus_bit, bit_strobe;
    logic sleep_req, sleep_ack, init_req, init_ack, wake_flag, tx_force_rec, cfg_wr_en, online;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    can_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sleep_wr(sleep_wr), .sleep_wdata(sleep_wdata),
        .init_wr(init_wr), .init_wdata(init_wdata), .wake_en(wake_en), .wake_clr(wake_clr),
        .halt_in_wait(halt_in_wait), .rx_busy(rx_busy), .tx_all_empty(tx_all_empty),
        .bus_off(bus_off), .bus_bit(bus_bit), .bit_strobe(bit_strobe),
        .sleep_req(sleep_req), .sleep_ack(sleep_ack), .init_req(init_req), .init_ack(init_ack),
        .wake_flag(wake_flag), .tx_force_rec(tx_force_rec), .cfg_wr_en(cfg_wr_en), .online(online)
    );

    // behavioural reference: mode 0 run, 1 sleep, 2 init, 3 resync
    int m_mode = 0;
    int m_sreq = 0, m_ireq = 0, m_flag = 0, m_bits = 0, m_runs = 0;

    always @(posedge clk) begin
        int nmode, nsreq, nireq;
        bit wake;
        if (!rst_n) begin
            m_mode = 0; m_sreq = 0; m_ireq = 0; m_flag = 0; m_bits = 0; m_runs = 0;
        end else begin
            wake  = (m_mode == 1) && (m_ireq == 0) && wake_en && bit_strobe && !bus_bit;
            nireq = m_ireq;
            if (init_wr) nireq = init_wdata ? 1 : ((m_mode == 2) ? 0 : m_ireq);
            nsreq = m_sreq;
            if (sleep_wr) begin
                if (sleep_wdata && m_flag == 0) nsreq = 1;
                if (!sleep_wdata && m_mode == 1) nsreq = 0;
            end
            if (wake) nsreq = 0;
            nmode = m_mode;
            if (m_ireq == 1) nmode = 2;
            else if (m_mode == 0) begin
                if (m_sreq == 1 && !rx_busy && tx_all_empty) nmode = 1;
            end else if (m_mode == 1) begin
                if (m_sreq == 0 || wake) nmode = 0;
            end else if (m_mode == 2) begin
                nmode = 3; m_bits = 0; m_runs = 0;
            end else if (bit_strobe) begin
                if (!bus_bit) m_bits = 0;
                else begin
                    m_bits++;
                    if (m_bits == 11) begin
                        m_bits = 0;
                        if (!bus_off) nmode = 0;
                        else begin
                            m_runs++;
                            if (m_runs == 128) nmode = 0;
                        end
                    end
                end
            end
            if (wake) m_flag = 1;
            else if (wake_clr) m_flag = 0;
            m_mode = nmode; m_sreq = nsreq; m_ireq = nireq;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 sleep_ack", sleep_ack, m_mode == 1);
            chk("R2 sleep_req", sleep_req, m_sreq == 1);
            chk("R3 init_req", init_req, m_ireq == 1);
            chk("R6 init_ack", init_ack, m_mode == 2);
            chk("R5 wake_flag", wake_flag, m_flag == 1);
            chk("R8 cfg_wr_en", cfg_wr_en, m_ireq == 1 && m_mode == 2);
            chk("R9 online", online, m_mode == 0);
            chk("R7 tx_force_rec", tx_force_rec, halt_in_wait || m_ireq == 1 || m_mode != 0);
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic sw_sleep(input logic v);
        sleep_wr = 1'b1; sleep_wdata = v; tick(); sleep_wr = 1'b0;
    endtask

    task automatic sw_init(input logic v);
        init_wr = 1'b1; init_wdata = v; tick(); init_wr = 1'b0;
    endtask

    task automatic send_bit(input logic v);
        bit_strobe = 1'b1; bus_bit = v; tick();
        bit_strobe = 1'b0; bus_bit = 1'b1; tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL all: watchdog expired, got running expected finished");
        summary();
    end

    initial begin
        rst_n = 0; sleep_wr = 0; sleep_wdata = 0; init_wr = 0; init_wdata = 0;
        wake_en = 0; wake_clr = 0; halt_in_wait = 0; rx_busy = 0; tx_all_empty = 1;
        bus_off = 0; bus_bit = 1; bit_strobe = 0;
        repeat (3) tick();
        rst_n = 1; tick();
        // R12 reset state
        chk("R12 online", online, 1'b1);
        chk("R12 sleep_ack", sleep_ack, 1'b0);
        chk("R12 init_ack", init_ack, 1'b0);
        chk("R12 wake_flag", wake_flag, 1'b0);

        // R1 busy bus holds sleep off, R2 clear ignored while pending
        rx_busy = 1; sw_sleep(1'b1); repeat (3) tick();
        chk("R1 no sleep while busy", sleep_ack, 1'b0);
        sw_sleep(1'b0);
        chk("R2 clear ignored", sleep_req, 1'b1);
        rx_busy = 0; tick();
        chk("R1 sleep entered", sleep_ack, 1'b1);
        chk("R7 forced in sleep", tx_force_rec, 1'b1);

        // R5 wake disabled then enabled
        send_bit(1'b0);
        chk("R5 ignored when disabled", sleep_ack, 1'b1);
        wake_en = 1; bit_strobe = 1; bus_bit = 0; tick();
        chk("R5 req cleared", sleep_req, 1'b0);
        chk("R5 flag set", wake_flag, 1'b1);
        chk("R5 running", online, 1'b1);
        bit_strobe = 0; bus_bit = 1; tick();

        // R4 set blocked by flag, R12 W1C
        sw_sleep(1'b1);
        chk("R4 set blocked", sleep_req, 1'b0);
        wake_clr = 1; tick(); wake_clr = 0;
        chk("R12 flag cleared", wake_flag, 1'b0);
        sw_sleep(1'b1); tick();
        chk("R1 sleep again", sleep_ack, 1'b1);
        sw_sleep(1'b0);
        chk("R2 clear accepted", sleep_req, 1'b0);
        tick();
        chk("R2 back to running", online, 1'b1);

        // R6/R3/R8 initialization handshake
        sw_init(1'b1);
        chk("R7 forced on request", tx_force_rec, 1'b1);
        chk("R8 no write before ack", cfg_wr_en, 1'b0);
        sw_init(1'b0);
        chk("R3 clear ignored", init_req, 1'b1);
        chk("R6 ack raised", init_ack, 1'b1);
        chk("R8 write enabled", cfg_wr_en, 1'b1);
        sw_init(1'b0);
        chk("R8 closed on clear", cfg_wr_en, 1'b0);
        tick();
        chk("R11 ack dropped", init_ack, 1'b0);
        chk("R11 not online", online, 1'b0);

        // R9/R10 normal rejoin
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        chk("R10 run restarted", online, 1'b0);
        send_bit(1'b1);
        chk("R9 rejoined", online, 1'b1);
        chk("R7 released", tx_force_rec, 1'b0);
        halt_in_wait = 1; tick();
        chk("R7 halted", tx_force_rec, 1'b1);
        halt_in_wait = 0; tick();

        // R9/R10 bus-off rejoin
        bus_off = 1; sw_init(1'b1); tick(); sw_init(1'b0); tick();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 0; i < 128 * 11 - 1; i++) send_bit(1'b1);
        chk("R10 busoff one short", online, 1'b0);
        send_bit(1'b1);
        chk("R9 busoff rejoined", online, 1'b1);
        bus_off = 0;

        // R6 from sleep, then R12 reset mid-run
        sw_sleep(1'b1); tick();
        chk("R1 sleep before init", sleep_ack, 1'b1);
        sw_init(1'b1); tick();
        chk("R6 init from sleep", init_ack, 1'b1);
        chk("R6 sleep ack low", sleep_ack, 1'b0);
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
        chk("R12 req cleared", init_req, 1'b0);
        chk("R12 sleep req cleared", sleep_req, 1'b0);
        chk("R12 running", online, 1'b1);
        summary();
    end

endmodule